// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block answers as a slave on a two-wire serial bus (SCL clock, SDA open-drain data) and fronts an 8192-byte memory held outside it. Both bus lines are sampled with the system clock. Start, stop and repeated start are recognised from the sampled lines. The first byte of a transfer selects the device and gives the direction. In a write transfer, two address bytes load a 13-bit address latch, and every later byte is stored at once. In a read transfer, bytes stream out of the latch position for as long as the master acknowledges them.

Each byte moves between the bus and the memory port within a few system clocks. There is no busy period. A byte is committed before its acknowledge slot, and a following transfer can begin straight away. A write-protect input can lock the top quarter of the address space against writes. The memory is reached through a synchronous port that has a one-cycle read latency.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe`=0), no memory strobe is raised, and the address latch holds 0.
- R2: The select byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal `strap_i`. Bit 0 gives the direction, and 1 means read. After a select byte that does not match, the block does not drive SDA until the next start.
- R3: In a write transfer, the two bytes that follow the select byte form the address, high byte first. The top three bits of the high byte are discarded, and the remaining 13 bits load the latch.
- R4: Each data byte of a write transfer is written to the latch address, is acknowledged, and advances the latch by one. A burst may be any length.
- R5: The latch wraps from 0x1FFF to 0x0000, in bursts of either direction.
- R6: A read transfer begins at the current latch value, which is kept between transfers. Bytes go out MSB first. An acknowledge from the master causes the next byte to be sent.
- R7: A repeated start after the address bytes ends the write transfer without any memory write. A read-select byte that follows reads from the newly loaded address.
- R8: A start or stop that arrives before the 8th bit of a data byte discards that byte. Memory and the latch stay unchanged.
- R9: While `wp_i` is 1, a data byte aimed at 0x1800..0x1FFF is not written and not acknowledged, and the latch stays where it is. While `wp_i` is 0, that range can be written.
- R10: A no-acknowledge or a stop in the 9th clock of a read byte ends the read, and SDA is released.
- R11: The memory write for a data byte completes before the acknowledge is sampled by the master.
- R12: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| strap_i | input | 3 | Device select straps |
| wp_i | input | 1 | Upper-quarter write protect |
| sda_oe | output | 1 | 1 drives SDA low, 0 releases it |
| mem_addr | output | 13 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe, data valid on the next cycle |
| mem_rdata | input | 8 | Memory read data |

## Verification
The bench targets the following corner cases:
- Address wrap at the top of the array, in both burst directions. A latch that saturates or spills into a 14th bit would return or overwrite the wrong bytes.
- A write to the first protected location. A design that advanced the latch after refusing the byte would make the next current-address read start one byte too late.
- A data byte cut off by a stop after four bits. A design that committed the partial byte would trigger a write the scoreboard never expected.
- A random read. If the design treated the repeated start as the next data byte, a spurious write would appear.
- A mismatched select byte, a read ended by a stop in the ninth clock, and a high address byte with its top bits set. Each of these catches a design that answers the wrong device, holds SDA low after the read ends, or keeps too many address bits.

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int AW = 13,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  input  logic          wp_i,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata
);
  localparam int HW = AW - 8;
  localparam logic [AW-1:0] ONE = 1;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK1, S_ACK2, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {K_DEV, K_AH, K_AL, K_DAT} kind_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  st_t st;
  kind_t kind;
  logic [2:0] cnt;
  logic [6:0] sr, txsr;
  logic [7:0] txbuf;
  logic ackd, rdmode, mack_ok, re_q;
  logic [AW-1:0] latch;
  logic [HW-1:0] ahi;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] nb = {sr, sda_s};
  wire sel_hit = (nb[7:4] == DEV_TYPE) && (nb[3:1] == strap_i);
  wire prot = wp_i && (&latch[AW-1:AW-2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      st <= S_IDLE;
      kind <= K_DEV;
      cnt <= '0;
      sr <= '0;
      txsr <= '0;
      txbuf <= '0;
      ackd <= 1'b0;
      rdmode <= 1'b0;
      mack_ok <= 1'b0;
      re_q <= 1'b0;
      latch <= '0;
      ahi <= '0;
      sda_oe <= 1'b0;
      mem_addr <= '0;
      mem_we <= 1'b0;
      mem_wdata <= '0;
      mem_re <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      re_q <= mem_re;
      if (re_q) txbuf <= mem_rdata;

      if (start_c) begin
        st <= S_RX;
        kind <= K_DEV;
        cnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            sr <= nb[6:0];
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              st <= S_ACK1;
              ackd <= 1'b1;
              rdmode <= 1'b0;
              case (kind)
                K_DEV: begin
                  ackd <= sel_hit;
                  rdmode <= nb[0];
                  kind <= K_AH;
                  if (sel_hit && nb[0]) begin
                    mem_re <= 1'b1;
                    mem_addr <= latch;
                  end
                end
                K_AH: begin
                  ahi <= nb[HW-1:0];
                  kind <= K_AL;
                end
                K_AL: begin
                  latch <= {ahi, nb};
                  kind <= K_DAT;
                end
                default: begin
                  if (prot) ackd <= 1'b0;
                  else begin
                    mem_we <= 1'b1;
                    mem_addr <= latch;
                    mem_wdata <= nb;
                    latch <= latch + ONE;
                  end
                end
              endcase
            end
          end
          S_ACK1: if (scl_fall) begin
            sda_oe <= ackd;
            st <= S_ACK2;
          end
          S_ACK2: if (scl_fall) begin
            cnt <= '0;
            if (!ackd) begin
              sda_oe <= 1'b0;
              st <= S_IDLE;
            end else if (rdmode) begin
              sda_oe <= ~txbuf[7];
              txsr <= txbuf[6:0];
              st <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st <= S_RX;
            end
          end
          S_TX: begin
            if (scl_rise && cnt == 3'd7) latch <= latch + ONE;
            if (scl_fall) begin
              cnt <= cnt + 3'd1;
              txsr <= {txsr[5:0], 1'b1};
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0;
                mack_ok <= 1'b0;
                st <= S_MACK;
              end else begin
                sda_oe <= ~txsr[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                mack_ok <= 1'b1;
                mem_re <= 1'b1;
                mem_addr <= latch;
              end else begin
                st <= S_IDLE;
              end
            end else if (scl_fall && mack_ok) begin
              sda_oe <= ~txbuf[7];
              txsr <= txbuf[6:0];
              cnt <= '0;
              st <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          wp_i,
  input logic          sda_oe,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re
);
  a_r9_no_protected_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !($past(wp_i) && (&mem_addr[AW-1:AW-2])));

  a_r12_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  a_r4_write_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  a_r6_read_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);

  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .wp_i(wp_i), .sda_oe(sda_oe),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/twi_mem_slave_test.sv
module twi_mem_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe, mem_we, mem_re;
  logic [12:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  wire sda_line = sda_m & ~sda_oe;

  twi_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .wp_i(wp), .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  logic [7:0] ram [8192];
  logic [7:0] mdl [8192];
  logic [20:0] exp_q [$];
  logic [20:0] e_item;
  int errs = 0, checks = 0;
  logic [12:0] lat = 13'h0;
  bit done = 0;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every write strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) chk(0, "R4/R7/R8 unexpected write", int'({mem_addr, mem_wdata}), 0);
      else begin
        e_item = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e_item, "R4 write addr/data", int'({mem_addr, mem_wdata}), int'(e_item));
      end
    end
  end

  task automatic hp(); repeat (4) @(negedge clk); endtask

  task automatic bit_out(input bit b);
    hp(); sda_m = b; hp(); scl = 1'b1; hp(); hp(); scl = 1'b0;
  endtask

  task automatic bit_in(output bit b);
    bit b2;
    sda_m = 1'b1; hp(); hp(); scl = 1'b1; hp(); b = sda_line;
    repeat (3) @(negedge clk);
    b2 = sda_line;
    chk(b == b2, "R12 SDA stable while SCL high", b2, b);
    @(negedge clk); scl = 1'b0;
  endtask

  task automatic do_start();
    sda_m = 1'b1; hp(); scl = 1'b1; hp(); sda_m = 1'b0; hp(); scl = 1'b0;
  endtask

  task automatic do_stop();
    hp(); sda_m = 1'b0; hp(); scl = 1'b1; hp(); sda_m = 1'b1; hp(); hp();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = !a;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    bit t;
    for (int i = 7; i >= 0; i--) begin
      bit_in(t);
      b[i] = t;
    end
    bit_out(!give_ack);
  endtask

  function automatic logic [7:0] sel(input bit rw);
    return {4'b1010, strap, rw};
  endfunction

  task automatic set_addr(input logic [15:0] a, input string tag);
    bit ack;
    do_start();
    wr_byte(sel(1'b0), ack); chk(ack, {tag, " select ack"}, ack, 1);
    wr_byte(a[15:8], ack); chk(ack, {tag, " addr hi ack"}, ack, 1);
    wr_byte(a[7:0], ack); chk(ack, {tag, " addr lo ack"}, ack, 1);
    lat = a[12:0];
  endtask

  task automatic write_burst(input logic [15:0] a, input int n, input logic [7:0] seed, input string tag);
    bit ack;
    logic [7:0] d;
    set_addr(a, tag);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k);
      exp_q.push_back({lat, d});
      mdl[lat] = d;
      wr_byte(d, ack);
      chk(ack, {tag, " data ack"}, ack, 1);
      chk(ram[lat] == d, "R11 byte stored by ack", ram[lat], d);
      lat = lat + 13'd1;
    end
    do_stop();
  endtask

  task automatic read_body(input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, b);
      chk(b == mdl[lat], tag, b, mdl[lat]);
      lat = lat + 13'd1;
    end
  endtask

  task automatic read_cur(input int n, input string tag);
    bit ack;
    do_start();
    wr_byte(sel(1'b1), ack); chk(ack, {tag, " read select ack"}, ack, 1);
    read_body(n, tag);
    repeat (6) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 SDA released after no-ack", sda_oe, 0);
    do_stop();
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < 8192; i++) begin
      mdl[i] = 8'((i * 37 + 11) ^ (i >> 5));
      ram[i] = mdl[i];
    end
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R1 reset outputs idle", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    read_cur(1, "R1 latch starts at zero");

    // R2: wrong strap, wrong type
    do_start();
    wr_byte({4'b1010, strap ^ 3'b010, 1'b0}, ack); chk(!ack, "R2 strap mismatch nack", ack, 0);
    wr_byte(8'h00, ack); chk(!ack, "R2 stays off bus after mismatch", ack, 0);
    do_stop();
    do_start();
    wr_byte({4'b1011, strap, 1'b1}, ack); chk(!ack, "R2 type mismatch nack", ack, 0);
    do_stop();

    // R3/R4: upper address bits dropped, burst with increment
    write_burst(16'hE005, 3, 8'h40, "R3 R4 burst");
    read_cur(2, "R6 current read continues");
    read_cur(1, "R6 latch persists");

    // R5: write wrap, then read wrap
    write_burst(16'h1FFE, 3, 8'hA0, "R5 write wrap");
    read_cur(1, "R5 latch after write wrap");
    set_addr(16'h1FFF, "R5");
    do_start();
    wr_byte(sel(1'b1), ack); chk(ack, "R7 read select after repeated start", ack, 1);
    read_body(2, "R5 read wrap");
    do_stop();

    // R7: random read
    set_addr(16'h0123, "R7");
    do_start();
    wr_byte(sel(1'b1), ack); chk(ack, "R7 random read select", ack, 1);
    read_body(3, "R7 random read data");
    do_stop();

    // R8: partial byte then stop / then start
    set_addr(16'h0200, "R8");
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    do_stop();
    read_cur(1, "R8 partial byte discarded by stop");
    set_addr(16'h0300, "R8");
    for (int i = 0; i < 5; i++) bit_out(1'b1);
    do_start();
    wr_byte(sel(1'b1), ack); chk(ack, "R8 select after abort", ack, 1);
    read_body(1, "R8 partial byte discarded by start");
    do_stop();

    // R9: write protect
    wp = 1'b1;
    set_addr(16'h17FF, "R9");
    exp_q.push_back({lat, 8'h5A}); mdl[lat] = 8'h5A;
    wr_byte(8'h5A, ack); chk(ack, "R9 below protected range acked", ack, 1);
    lat = lat + 13'd1;
    wr_byte(8'hC3, ack); chk(!ack, "R9 protected byte nacked", ack, 0);
    do_stop();
    chk(ram[13'h1800] == mdl[13'h1800], "R9 protected byte unchanged", ram[13'h1800], mdl[13'h1800]);
    read_cur(1, "R9 latch held at 1800");
    wp = 1'b0;
    write_burst(16'h1800, 1, 8'h77, "R9 unprotected write");

    // R10: stop in the ninth clock of a read
    set_addr(16'h0040, "R10");
    do_start();
    wr_byte(sel(1'b1), ack); chk(ack, "R10 read select", ack, 1);
    for (int i = 7; i >= 0; i--) begin
      bit t;
      bit_in(t);
      b[i] = t;
    end
    chk(b == mdl[lat], "R10 byte before stop", b, mdl[lat]);
    lat = lat + 13'd1;
    do_stop();
    repeat (6) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 SDA released after stop", sda_oe, 0);
    read_cur(1, "R10 next read after stop-ended read");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
    done = 1;
    report();
  end
endmodule